// File: doc/BRIEF.md
# Port Transmit Scheduler with Drain Queue

This block decides what a cache port places on a send channel whose receiver may refuse a transfer. Three sources compete. Responses from the cache come first: they are sent at once when nothing is queued, and otherwise they wait in a small first-in first-out drain queue. Requests come second. On a memory-side instance they are miss-handling requests offered by the cache core. On a CPU-side instance they are coherence requests.

A refused transfer puts the block into a waiting state. While waiting, it makes no attempt of its own until the peer pulses the retry input, and that retry pulse starts an attempt in the same cycle. After an accepted transfer the next attempt follows in the very next cycle if work remains. On the CPU side, a refused coherence packet is captured and sent again unchanged, so coherence traffic is never reordered. On the memory side, the core is told the outcome of each request attempt and offers its current pending request again. A CPU-side or memory-side variant is chosen by a parameter.

Top module: `port_tx_sched`

## Requirements
- R1: After reset the send channel is idle (`tx_valid_o` low), `rsp_ready_o` is high, and the block is not waiting for a retry.
- R2: While waiting for a retry, `tx_valid_o` stays low in every cycle without `retry_i`. A `retry_i` pulse makes an attempt in the same cycle. If that attempt is refused, the block keeps waiting.
- R3: When the drain queue holds entries, the head entry is offered ahead of any request. It is removed only when accepted. A refusal of any transfer enters the waiting state from the next cycle.
- R4: On a memory-side instance (`CPU_SIDE`=0), with no response to send, a pending request (`req_pend_i`) is offered from `req_data_i`. `req_res_vld_o` pulses in that cycle, and `req_res_ok_o` equals the accept outcome. After a refusal the retry attempt sends the source's current request.
- R5: On a CPU-side instance (`CPU_SIDE`=1), a refused request is captured and resent with identical data on the retry, whatever `req_data_i` shows by then. The source regards a request as consumed at its first attempt.
- R6: After an accepted transfer, when more work is present, the next attempt is made in the following cycle.
- R7: `tx_kind_o` encodes the transfer: 0 = response with success status, 1 = response with nack status (its `rsp_nack_i` was set), 2 = request.
- R8: A new response is sent directly when the queue is empty and the block is not waiting. Otherwise it is appended to the queue. A refused direct response is appended to the queue and the block waits.
- R9: The drain queue holds `DEPTH` entries (default 4) in strict arrival order. `rsp_ready_o` is low while it is full.
- R10: A `retry_i` pulse while not waiting raises `retry_err_o` in that cycle and otherwise changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsp_valid_i | input | 1 | New response offered |
| rsp_nack_i | input | 1 | Response carries nack status |
| rsp_data_i | input | DW | Response payload |
| rsp_ready_o | output | 1 | Response can be taken (queue not full) |
| req_pend_i | input | 1 | A request is pending at the source |
| req_data_i | input | DW | Pending request payload |
| req_res_vld_o | output | 1 | A request was attempted this cycle |
| req_res_ok_o | output | 1 | Outcome of that attempt (1 = accepted) |
| tx_valid_o | output | 1 | Transfer offered on the send channel |
| tx_kind_o | output | 2 | Transfer kind (see R7) |
| tx_data_o | output | DW | Transfer payload |
| tx_accept_i | input | 1 | Peer accepts the offered transfer |
| retry_i | input | 1 | Retry pulse from the peer |
| retry_err_o | output | 1 | Retry received while not waiting |

## Verification
A table-driven sequence mixes direct responses with and without nack, accepted and refused memory-side requests, and responses that arrive while waiting. This separates direct sending from queuing and shows that the queue drains before requests. A stray retry is included to confirm that it only raises the error flag. Directed cases fill the queue to capacity, which shows the ready drop, the arrival order and the back-to-back drain after a single retry. They also refuse a direct response twice, to tell a retry-triggered attempt from the silent waiting cycles. A CPU-side and a memory-side instance receive the same refused request and then a changed source payload on the retry, which shows a held resend versus a fresh fetch.

// File: rtl/port_tx_pkg.sv
package port_tx_pkg;
  typedef enum logic [1:0] {
    TXK_RSP_OK   = 2'd0,
    TXK_RSP_NACK = 2'd1,
    TXK_REQ      = 2'd2
  } tx_kind_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_DRAIN,
    SRC_DIRECT,
    SRC_HOLD,
    SRC_REQ
  } tx_src_e;
endpackage

// File: rtl/port_tx_drain_fifo.sv
module port_tx_drain_fifo #(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + 1'b1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/port_tx_coh_hold.sv
module port_tx_coh_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          clr_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/port_tx_sched.sv
module port_tx_sched
  import port_tx_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned DEPTH    = 4,
  parameter bit          CPU_SIDE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rsp_valid_i,
  input  logic          rsp_nack_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          rsp_ready_o,
  input  logic          req_pend_i,
  input  logic [DW-1:0] req_data_i,
  output logic          req_res_vld_o,
  output logic          req_res_ok_o,
  output logic          tx_valid_o,
  output logic [1:0]    tx_kind_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_accept_i,
  input  logic          retry_i,
  output logic          retry_err_o
);
  localparam int unsigned EW = DW + 1;

  logic          waiting_q;
  logic          attempt_en;
  tx_src_e       src;
  logic          q_empty, q_full, q_push, q_pop;
  logic [EW-1:0] q_head;
  logic          hold_v, hold_load, hold_clr;
  logic [DW-1:0] hold_d;
  logic          rsp_fire, sent;

  assign attempt_en = !waiting_q || retry_i;
  assign rsp_fire   = rsp_valid_i && rsp_ready_o;

  always_comb begin
    if (!q_empty)                       src = SRC_DRAIN;
    else if (rsp_valid_i && !waiting_q) src = SRC_DIRECT;
    else if (hold_v)                    src = SRC_HOLD;
    else if (req_pend_i)                src = SRC_REQ;
    else                                src = SRC_NONE;
  end

  always_comb begin
    tx_kind_o = TXK_REQ;
    tx_data_o = req_data_i;
    case (src)
      SRC_DRAIN: begin
        tx_kind_o = q_head[DW] ? TXK_RSP_NACK : TXK_RSP_OK;
        tx_data_o = q_head[DW-1:0];
      end
      SRC_DIRECT: begin
        tx_kind_o = rsp_nack_i ? TXK_RSP_NACK : TXK_RSP_OK;
        tx_data_o = rsp_data_i;
      end
      SRC_HOLD: tx_data_o = hold_d;
      default:  ;
    endcase
  end

  assign tx_valid_o    = attempt_en && (src != SRC_NONE);
  assign sent          = tx_valid_o && tx_accept_i;
  assign q_pop         = sent && (src == SRC_DRAIN);
  assign q_push        = rsp_fire && !(src == SRC_DIRECT && tx_accept_i);
  assign rsp_ready_o   = !q_full;
  assign req_res_vld_o = tx_valid_o && (src == SRC_REQ || src == SRC_HOLD);
  assign req_res_ok_o  = tx_accept_i;
  assign retry_err_o   = retry_i && !waiting_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         waiting_q <= 1'b0;
    else if (attempt_en) waiting_q <= tx_valid_o && !tx_accept_i;
  end

  port_tx_drain_fifo #(.DW(EW), .DEPTH(DEPTH)) u_drain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (q_push),
    .data_i  ({rsp_nack_i, rsp_data_i}),
    .pop_i   (q_pop),
    .head_o  (q_head),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  assign hold_load = tx_valid_o && (src == SRC_REQ) && !tx_accept_i;
  assign hold_clr  = sent && (src == SRC_HOLD);

  generate
    if (CPU_SIDE) begin : g_coh
      port_tx_coh_hold #(.DW(DW)) u_hold (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (hold_load),
        .clr_i   (hold_clr),
        .data_i  (req_data_i),
        .valid_o (hold_v),
        .data_o  (hold_d)
      );
    end else begin : g_mem
      logic unused_hold;
      assign unused_hold = hold_load ^ hold_clr;
      assign hold_v      = 1'b0;
      assign hold_d      = '0;
    end
  endgenerate
endmodule

// File: rtl/port_tx_sched_chk.sv
module port_tx_sched_chk
  import port_tx_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter bit          CPU_SIDE = 1'b0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          retry_i,
  input logic          tx_valid_o,
  input logic [1:0]    tx_kind_o,
  input logic [DW-1:0] tx_data_o,
  input logic          tx_accept_i,
  input logic          rsp_ready_o,
  input logic          retry_err_o,
  input logic          waiting_q,
  input logic          q_empty,
  input logic          q_full
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  p_quiet_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting_q && !retry_i |-> !tx_valid_o);

  p_refuse_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_accept_i |=> waiting_q);

  p_drain_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_empty && tx_valid_o |-> tx_kind_o != TXK_REQ);

  p_full_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_full |-> !rsp_ready_o);

  p_stray_retry_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_err_o && !tx_valid_o |=> !waiting_q);

  generate
    if (CPU_SIDE) begin : g_coh_chk
      p_hold_resend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && $past(tx_valid_o && tx_kind_o == TXK_REQ && !tx_accept_i)
          && tx_valid_o && tx_kind_o == TXK_REQ
        |-> tx_data_o == $past(tx_data_o));
    end
  endgenerate
endmodule

bind port_tx_sched port_tx_sched_chk #(.DW(DW), .CPU_SIDE(CPU_SIDE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .retry_i     (retry_i),
  .tx_valid_o  (tx_valid_o),
  .tx_kind_o   (tx_kind_o),
  .tx_data_o   (tx_data_o),
  .tx_accept_i (tx_accept_i),
  .rsp_ready_o (rsp_ready_o),
  .retry_err_o (retry_err_o),
  .waiting_q   (waiting_q),
  .q_empty     (q_empty),
  .q_full      (q_full)
);

// File: tb/port_tx_sched_tb_top.sv
module port_tx_sched_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       rv, rn, qp, acc, rty;
  logic [7:0] rd, qd;
  logic       m_rdy, m_rv, m_ok, m_tv, m_err;
  logic [1:0] m_k;
  logic [7:0] m_d;
  logic       c_rdy, c_rv, c_ok, c_tv, c_err;
  logic [1:0] c_k;
  logic [7:0] c_d;

  port_tx_sched #(.DW(8), .DEPTH(4), .CPU_SIDE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rsp_valid_i(rv), .rsp_nack_i(rn), .rsp_data_i(rd),
    .rsp_ready_o(m_rdy), .req_pend_i(qp), .req_data_i(qd), .req_res_vld_o(m_rv),
    .req_res_ok_o(m_ok), .tx_valid_o(m_tv), .tx_kind_o(m_k), .tx_data_o(m_d),
    .tx_accept_i(acc), .retry_i(rty), .retry_err_o(m_err));

  port_tx_sched #(.DW(8), .DEPTH(4), .CPU_SIDE(1'b1)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_n), .rsp_valid_i(rv), .rsp_nack_i(rn), .rsp_data_i(rd),
    .rsp_ready_o(c_rdy), .req_pend_i(qp), .req_data_i(qd), .req_res_vld_o(c_rv),
    .req_res_ok_o(c_ok), .tx_valid_o(c_tv), .tx_kind_o(c_k), .tx_data_o(c_d),
    .tx_accept_i(acc), .retry_i(rty), .retry_err_o(c_err));

  typedef struct packed {
    logic rv, rn; logic [7:0] rd; logic qp; logic [7:0] qd; logic acc, rty;
    logic ev; logic [1:0] ek; logic [7:0] ed; logic erdy, erv, eok, eerr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,2'd0,8'h00,1'b1,1'b0,1'b0,1'b0}, // idle
    '{1'b1,1'b0,8'hA1,1'b0,8'h00,1'b1,1'b0, 1'b1,2'd0,8'hA1,1'b1,1'b0,1'b0,1'b0}, // R8 R7 direct ok
    '{1'b1,1'b1,8'hA2,1'b0,8'h00,1'b1,1'b0, 1'b1,2'd1,8'hA2,1'b1,1'b0,1'b0,1'b0}, // R7 nack
    '{1'b0,1'b0,8'h00,1'b1,8'hB1,1'b1,1'b0, 1'b1,2'd2,8'hB1,1'b1,1'b1,1'b1,1'b0}, // R4 ok
    '{1'b0,1'b0,8'h00,1'b1,8'hB2,1'b0,1'b0, 1'b1,2'd2,8'hB2,1'b1,1'b1,1'b0,1'b0}, // R4 refused
    '{1'b1,1'b0,8'hC1,1'b1,8'hB2,1'b1,1'b0, 1'b0,2'd0,8'h00,1'b1,1'b0,1'b0,1'b0}, // R2 R8 queued
    '{1'b1,1'b1,8'hC2,1'b1,8'hB2,1'b1,1'b0, 1'b0,2'd0,8'h00,1'b1,1'b0,1'b0,1'b0}, // R2 R8 queued
    '{1'b0,1'b0,8'h00,1'b1,8'hB2,1'b1,1'b1, 1'b1,2'd0,8'hC1,1'b1,1'b0,1'b0,1'b0}, // R3 head first
    '{1'b0,1'b0,8'h00,1'b1,8'hB2,1'b1,1'b0, 1'b1,2'd1,8'hC2,1'b1,1'b0,1'b0,1'b0}, // R3 R6
    '{1'b0,1'b0,8'h00,1'b1,8'hB2,1'b1,1'b0, 1'b1,2'd2,8'hB2,1'b1,1'b1,1'b1,1'b0}, // R4 R6
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,1'b1, 1'b0,2'd0,8'h00,1'b1,1'b0,1'b0,1'b1}, // R10 stray
    '{1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,2'd0,8'h00,1'b1,1'b0,1'b0,1'b0}  // R10 no effect
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic a_rv, a_rn, input logic [7:0] a_rd,
                       input logic a_qp, input logic [7:0] a_qd, input logic a_acc, a_rty);
    @(negedge clk);
    rv = a_rv; rn = a_rn; rd = a_rd; qp = a_qp; qd = a_qd; acc = a_acc; rty = a_rty;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rv = 0; rn = 0; rd = 0; qp = 0; qd = 0; acc = 0; rty = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk("R1 idle after reset", {m_tv, m_rdy, m_err}, {1'b0, 1'b1, 1'b0});

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v.rv, v.rn, v.rd, v.qp, v.qd, v.acc, v.rty);
      chk($sformatf("vector %0d", i),
          {m_tv, (v.ev ? m_k : 2'd0), (v.ev ? m_d : 8'd0), m_rdy, m_rv, (v.erv ? m_ok : 1'b0), m_err},
          {v.ev, v.ek, v.ed, v.erdy, v.erv, v.eok, v.eerr});
    end

    // R9 fill the queue while waiting, then drain in order
    do_reset();
    drive(0, 0, 8'h00, 1, 8'h30, 0, 0);
    for (int i = 0; i < 4; i++) drive(1, 0, 8'h10 + 8'(i), 1, 8'h30, 0, 0);
    drive(0, 0, 8'h00, 1, 8'h30, 1, 0);
    chk("R9 ready low when full", {m_rdy, m_tv}, {1'b0, 1'b0});
    drive(0, 0, 8'h00, 1, 8'h30, 1, 1);
    chk("R9 first entry on retry", {m_tv, m_k, m_d}, {1'b1, 2'd0, 8'h10});
    for (int i = 1; i < 4; i++) begin
      drive(0, 0, 8'h00, 1, 8'h30, 1, 0);
      chk("R6 R9 back-to-back order", {m_tv, m_d, m_rdy}, {1'b1, 8'h10 + 8'(i), 1'b1});
    end
    drive(0, 0, 8'h00, 1, 8'h30, 1, 0);
    chk("R3 request after drain", {m_tv, m_k, m_d}, {1'b1, 2'd2, 8'h30});

    // R8 refused direct response is queued; R2 refused retry keeps waiting
    do_reset();
    drive(1, 1, 8'h55, 0, 8'h00, 0, 0);
    chk("R8 direct attempt", {m_tv, m_k, m_d}, {1'b1, 2'd1, 8'h55});
    drive(0, 0, 8'h00, 0, 8'h00, 1, 0);
    chk("R2 silent while waiting", {31'd0, m_tv}, 32'd0);
    drive(0, 0, 8'h00, 0, 8'h00, 0, 1);
    chk("R8 queued copy on retry", {m_tv, m_k, m_d, m_err}, {1'b1, 2'd1, 8'h55, 1'b0});
    drive(0, 0, 8'h00, 0, 8'h00, 1, 0);
    chk("R2 still waiting after refused retry", {31'd0, m_tv}, 32'd0);
    drive(0, 0, 8'h00, 0, 8'h00, 1, 1);
    chk("R2 retry accepted", {m_tv, m_d}, {1'b1, 8'h55});
    drive(0, 0, 8'h00, 0, 8'h00, 1, 0);
    chk("R3 entry removed after accept", {31'd0, m_tv}, 32'd0);

    // R5 CPU side holds refused packet; R4 memory side refetches
    do_reset();
    drive(0, 0, 8'h00, 1, 8'h77, 0, 0);
    chk("R5 first attempt refused", {c_tv, c_k, c_d, c_rv, c_ok}, {1'b1, 2'd2, 8'h77, 1'b1, 1'b0});
    drive(0, 0, 8'h00, 1, 8'h88, 1, 1);
    chk("R5 held packet resent", {c_tv, c_k, c_d, c_rv, c_ok}, {1'b1, 2'd2, 8'h77, 1'b1, 1'b1});
    chk("R4 memory side sends current request", {m_tv, m_d, m_rv, m_ok}, {1'b1, 8'h88, 1'b1, 1'b1});
    drive(0, 0, 8'h00, 1, 8'h88, 1, 0);
    chk("R5 next request after resend", {c_tv, c_d}, {1'b1, 8'h88});
    drive(0, 0, 8'h00, 0, 8'h00, 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule